// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC. For every incoming frame it decides whether the frame is kept, using only the 48-bit destination address. The address is presented on a bus with octet 0 (the first octet on the wire) in bits 7:0 and octet 5 in bits 47:40, qualified by a one-cycle valid strobe. One clock later the block reports a decision: accept or reject, together with a code that says why.

Three mechanisms can accept a frame. The first is a bank of eight exact-match address entries. Entry 0 is intended for the station's own address and the other seven for extra unicast or group addresses. The second is a 64-bit group hash table, indexed by a 6-bit XOR fold of the address. The third is a promiscuous copy-all switch. A broadcast-block switch can reject the all-ones address. All storage is loaded through a simple word-wide register write port. Each entry is written as a low word and a high word, and writing the low word takes the entry out of service until its high word is written again.

Top module: `rx_addr_filter`

## Requirements
- R1: There are eight exact entries. Register address 2k loads the low word of entry k (octet 0 in bits 7:0, octet 1 in 15:8, octet 2 in 23:16, octet 3 in 31:24). Address 2k+1 loads its high word (octet 4 in bits 7:0, octet 5 in 15:8; bits 31:16 are ignored). An armed entry whose 48 stored bits equal the address gives an exact hit.
- R2: A low-word write disarms that entry and a high-word write arms it. A disarmed entry never hits, whatever it holds.
- R3: The hash index is 6 bits. Address bits are visited from octet 0 to octet 5, least significant bit first within each octet, and the n-th visited bit (n = 0..47) is XORed into index bit n mod 6.
- R4: Register address 16 holds the low hash word and 17 the high hash word. An index below 32 selects that bit of the low word; an index of 32 or more selects bit (index - 32) of the high word. A group address (octet 0 bit 0 set) that misses every armed entry gives a group hit when hashing is enabled and the selected bit is 1.
- R5: The hash table has no effect on unicast addresses or while hashing is disabled.
- R6: Register address 18 holds the control bits: bit 0 copy-all, bit 1 hash enable, bit 2 broadcast block. With copy-all set, every frame is accepted. The promiscuous reason is reported only when there is no exact or group hit.
- R7: The all-ones address is accepted with the group reason while broadcast block is clear. It is rejected while broadcast block is set, even when an entry or hash bit would match, unless copy-all is set.
- R8: The decision output `dec_valid` pulses exactly one clock after `da_valid`. The reason codes are 0 reject, 1 exact hit, 2 group hit and 3 promiscuous, and `dec_accept` is 1 exactly when the reason is not 0.
- R9: After reset all entries are disarmed, both hash words are zero and all control bits are clear. A unicast lookup is then rejected and a broadcast is accepted as a group hit.
- R10: A lookup in the same cycle as a register write is judged on the state held before that write.
- R11: An exact hit takes precedence over a group hit for the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register word address |
| wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, octet 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid, one clock after da_valid |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 2 | 0 reject, 1 exact, 2 group, 3 promiscuous |

## Verification
The two functions that can meet in one cycle are a register write to an entry and a lookup of the address that entry holds. The bench drives a low-word write to an armed entry together with a lookup of its address, and expects an exact hit. It then drives a high-word write together with a lookup of the disarmed entry, and expects a reject. In each case a follow-up lookup must show the new arming state, so the result depends only on the state held before the write.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_W = 48;
  localparam int HASH_W = 6;

  typedef enum logic [1:0] {
    RSN_REJECT  = 2'd0,
    RSN_EXACT   = 2'd1,
    RSN_GROUP   = 2'd2,
    RSN_PROMISC = 2'd3
  } rsn_e;

  // XOR fold: address bit n lands on index bit n mod HASH_W
  function automatic logic [HASH_W-1:0] hash_index(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int n = 0; n < ADDR_W; n++) begin
      h[n % HASH_W] = h[n % HASH_W] ^ a[n];
    end
    return h;
  endfunction
endpackage

// File: rtl/rxaf_entry_bank.sv
module rxaf_entry_bank #(
  parameter int N  = 8,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [rxaf_pkg::ADDR_W-1:0] da,
  output logic                       hit,
  output logic [N-1:0]               armed,
  output logic [N-1:0]               lo_sel,
  output logic [N-1:0]               hi_sel
);
  localparam int HI_W = rxaf_pkg::ADDR_W - DW;

  logic [N-1:0] match;

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic [DW-1:0]   lo_q;
    logic [HI_W-1:0] hi_q;
    logic            armed_q;

    assign lo_sel[k] = wr_en && (wr_addr == AW'(2 * k));
    assign hi_sel[k] = wr_en && (wr_addr == AW'(2 * k + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q    <= '0;
        hi_q    <= '0;
        armed_q <= 1'b0;
      end else begin
        if (lo_sel[k]) begin
          lo_q    <= wr_data;
          armed_q <= 1'b0;
        end
        if (hi_sel[k]) begin
          hi_q    <= wr_data[HI_W-1:0];
          armed_q <= 1'b1;
        end
      end
    end

    assign armed[k] = armed_q;
    assign match[k] = armed_q && ({hi_q, lo_q} == da);
  end

  assign hit = |match;
endmodule

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs #(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter int HASH_LO_A = 16,
  parameter int HASH_HI_A = 17,
  parameter int CTRL_A    = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] hash_lo,
  output logic [DW-1:0] hash_hi,
  output logic          copy_all,
  output logic          hash_en,
  output logic          bcast_dis
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hash_lo   <= '0;
      hash_hi   <= '0;
      copy_all  <= 1'b0;
      hash_en   <= 1'b0;
      bcast_dis <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(HASH_LO_A)) hash_lo <= wr_data;
      if (wr_addr == AW'(HASH_HI_A)) hash_hi <= wr_data;
      if (wr_addr == AW'(CTRL_A)) begin
        copy_all  <= wr_data[0];
        hash_en   <= wr_data[1];
        bcast_dis <= wr_data[2];
      end
    end
  end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide #(
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       da_valid,
  input  logic [rxaf_pkg::ADDR_W-1:0] da,
  input  logic                       exact_hit,
  input  logic [DW-1:0]              hash_lo,
  input  logic [DW-1:0]              hash_hi,
  input  logic                       copy_all,
  input  logic                       hash_en,
  input  logic                       bcast_dis,
  output logic                       dec_valid,
  output logic                       dec_accept,
  output logic [1:0]                 dec_reason
);
  import rxaf_pkg::*;
  localparam int SEL_W = $clog2(DW);

  logic [HASH_W-1:0] hidx;
  logic hbit, is_mcast, is_bcast, blocked, exact_ok, grp_ok, acc_d;
  rsn_e rsn_d;

  assign hidx     = hash_index(da);
  assign hbit     = hidx[SEL_W] ? hash_hi[hidx[SEL_W-1:0]] : hash_lo[hidx[SEL_W-1:0]];
  assign is_mcast = da[0];
  assign is_bcast = &da;
  assign blocked  = is_bcast && bcast_dis;
  assign exact_ok = exact_hit && !blocked;
  assign grp_ok   = !blocked && !exact_hit && is_mcast && ((hash_en && hbit) || is_bcast);
  assign acc_d    = copy_all || exact_ok || grp_ok;

  always_comb begin
    if (exact_ok)      rsn_d = RSN_EXACT;
    else if (grp_ok)   rsn_d = RSN_GROUP;
    else if (copy_all) rsn_d = RSN_PROMISC;
    else               rsn_d = RSN_REJECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_REJECT;
    end else begin
      dec_valid  <= da_valid;
      dec_accept <= da_valid && acc_d;
      dec_reason <= da_valid ? rsn_d : RSN_REJECT;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_ENTRIES = 8,
  parameter int REG_AW      = 5,
  parameter int DATA_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_AW-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        da_valid,
  input  logic [rxaf_pkg::ADDR_W-1:0] da,
  output logic                        dec_valid,
  output logic                        dec_accept,
  output logic [1:0]                  dec_reason
);
  localparam int HASH_LO_A = 2 * NUM_ENTRIES;
  localparam int HASH_HI_A = HASH_LO_A + 1;
  localparam int CTRL_A    = HASH_LO_A + 2;

  logic                   ent_hit;
  logic [NUM_ENTRIES-1:0] ent_armed, ent_lo_sel, ent_hi_sel;
  logic [DATA_W-1:0]      cfg_hash_lo, cfg_hash_hi;
  logic                   cfg_copy_all, cfg_hash_en, cfg_bcast_dis;

  rxaf_entry_bank #(.N(NUM_ENTRIES), .AW(REG_AW), .DW(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .da(da), .hit(ent_hit), .armed(ent_armed), .lo_sel(ent_lo_sel), .hi_sel(ent_hi_sel)
  );

  rxaf_cfg_regs #(.AW(REG_AW), .DW(DATA_W), .HASH_LO_A(HASH_LO_A),
                  .HASH_HI_A(HASH_HI_A), .CTRL_A(CTRL_A)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hash_lo(cfg_hash_lo), .hash_hi(cfg_hash_hi), .copy_all(cfg_copy_all),
    .hash_en(cfg_hash_en), .bcast_dis(cfg_bcast_dis)
  );

  rxaf_decide #(.DW(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da), .exact_hit(ent_hit),
    .hash_lo(cfg_hash_lo), .hash_hi(cfg_hash_hi), .copy_all(cfg_copy_all),
    .hash_en(cfg_hash_en), .bcast_dis(cfg_bcast_dis),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int N = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        da_valid,
  input logic [rxaf_pkg::ADDR_W-1:0] da,
  input logic [N-1:0]                lo_sel,
  input logic [N-1:0]                hi_sel,
  input logic [N-1:0]                armed,
  input logic                        copy_all,
  input logic                        bcast_dis,
  input logic                        dec_valid,
  input logic                        dec_accept,
  input logic [1:0]                  dec_reason
);
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !dec_valid);
  a_r8_accept_code: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_reason != 2'd0)));
  a_r2_lo_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_sel != '0) && (hi_sel == '0) |=> ((armed & $past(lo_sel)) == '0));
  a_r2_hi_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_sel != '0) |=> ((armed & $past(hi_sel)) == $past(hi_sel)));
  a_r6_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && copy_all |=> dec_accept);
  a_r7_bcast_block: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && (&da) && bcast_dis && !copy_all |=> !dec_accept);
  a_r1_exact_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && (armed == '0) |=> (dec_reason != 2'd1));
endmodule

bind rx_addr_filter rxaf_checker #(.N(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
  .lo_sel(ent_lo_sel), .hi_sel(ent_hi_sel), .armed(ent_armed),
  .copy_all(cfg_copy_all), .bcast_dis(cfg_bcast_dis),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, da_valid;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [47:0] da;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_reason;
  int n_chk = 0, n_pass = 0;
  bit done = 0;

  localparam logic [1:0] REJ = 2'd0, EXA = 2'd1, GRP = 2'd2, PRO = 2'd3;
  localparam logic [4:0] A_HLO = 5'd16, A_HHI = 5'd17, A_CTL = 5'd18;
  localparam logic [47:0] BCAST = 48'hffff_ffff_ffff;

  always #10 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .da_valid(da_valid), .da(da), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_reason(dec_reason)
  );

  // reference hash: rolling position counter that wraps at six
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    int pos = 0;
    for (int o = 0; o < 6; o++) begin
      for (int b = 0; b < 8; b++) begin
        h[pos] = h[pos] ^ a[8*o+b];
        pos = pos + 1;
        if (pos == 6) pos = 0;
      end
    end
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_entry(input int k, input logic [47:0] a);
    wr(5'(2*k), a[31:0]);
    wr(5'(2*k+1), {16'hdead, a[47:32]});
  endtask

  task automatic look_wr(input logic [47:0] a, input bit w, input logic [4:0] wa,
                         input logic [31:0] wd, input logic [1:0] exp, input string tag);
    @(negedge clk);
    da_valid = 1'b1; da = a;
    if (w) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
    @(negedge clk);
    da_valid = 1'b0; wr_en = 1'b0;
    chk(dec_valid && dec_reason == exp && dec_accept == (exp != REJ), tag,
        {61'(dec_valid), dec_accept, dec_reason}, {61'd1, exp != REJ, exp});
  endtask

  task automatic look(input logic [47:0] a, input logic [1:0] exp, input string tag);
    look_wr(a, 1'b0, 5'd0, 32'd0, exp, tag);
  endtask

  task automatic set_hash_bit(input logic [5:0] idx);
    if (idx >= 6'd32) begin wr(A_HLO, 32'd0); wr(A_HHI, 32'd1 << (idx - 6'd32)); end
    else begin wr(A_HLO, 32'd1 << idx); wr(A_HHI, 32'd0); end
  endtask

  localparam logic [47:0] STN  = 48'h5544_3322_1100;
  localparam logic [47:0] ALT  = 48'h0a0b_0c0d_0e10;
  localparam logic [47:0] E3   = 48'h7777_0000_beee;
  localparam logic [47:0] E5   = 48'h1234_5678_9abc;
  localparam logic [47:0] UNK  = 48'h9999_8888_7776;
  localparam logic [47:0] M1   = 48'h0000_0000_0001;
  localparam logic [47:0] M2   = 48'h0000_0000_0021;
  localparam logic [47:0] M3   = 48'h0100_5e00_0033;

  task automatic t_reset();
    chk(!dec_valid, "R9 dec_valid low after reset", 64'(dec_valid), 64'd0);
    look(UNK, REJ, "R9 unicast rejected after reset");
    look(M1, REJ, "R9 group rejected after reset (hash off)");
    look(BCAST, GRP, "R9/R7 broadcast accepted after reset");
  endtask

  task automatic t_exact();
    set_entry(0, STN);
    set_entry(7, ALT);
    look(STN, EXA, "R1 station entry 0 hit");
    look(ALT, EXA, "R1 entry 7 hit");
    look(STN ^ 48'h0100_0000_0000, REJ, "R1 octet5 differs");
    look(STN ^ 48'h0000_0000_0080, REJ, "R1 octet0 differs");
  endtask

  task automatic t_arming();
    wr(5'd6, E3[31:0]);
    look(E3, REJ, "R2 low only not armed");
    wr(5'd7, {16'h0, E3[47:32]});
    look(E3, EXA, "R2 high write arms");
    wr(5'd6, E3[31:0]);
    look(E3, REJ, "R2 low rewrite disarms");
    wr(5'd7, {16'h0, E3[47:32]});
    look(E3, EXA, "R2 rearmed");
  endtask

  task automatic t_same_cycle();
    set_entry(5, E5);
    look_wr(E5, 1'b1, 5'd10, E5[31:0], EXA, "R10 lookup with low write sees old armed");
    look(E5, REJ, "R10 disarm visible after");
    look_wr(E5, 1'b1, 5'd11, {16'h0, E5[47:32]}, REJ, "R10 lookup with high write sees old disarmed");
    look(E5, EXA, "R10 arm visible after");
  endtask

  task automatic t_hash();
    logic [5:0] i1, i2, i3;
    i1 = ref_hash(M1); i2 = ref_hash(M2); i3 = ref_hash(M3);
    wr(A_CTL, 32'h2);
    wr(A_HLO, 32'hffff_ffff); wr(A_HHI, 32'h0);
    look(M1, (i1 < 6'd32) ? GRP : REJ, "R4 low word all ones, M1");
    look(M2, (i2 < 6'd32) ? GRP : REJ, "R4 low word all ones, M2");
    look(M3, (i3 < 6'd32) ? GRP : REJ, "R4 low word all ones, M3");
    wr(A_HLO, 32'h0); wr(A_HHI, 32'hffff_ffff);
    look(M2, (i2 >= 6'd32) ? GRP : REJ, "R4 high word all ones, M2");
    set_hash_bit(i1);
    look(M1, GRP, "R3 single bit at M1 index");
    look(M2, (i2 == i1) ? GRP : REJ, "R3 single bit misses M2");
    set_hash_bit(i3);
    look(M3, GRP, "R3 single bit at M3 index");
    look(M1, (i1 == i3) ? GRP : REJ, "R3 single bit misses M1");
  endtask

  task automatic t_hash_off();
    wr(A_HLO, 32'hffff_ffff); wr(A_HHI, 32'hffff_ffff);
    look(UNK, REJ, "R5 unicast ignores full hash table");
    wr(A_CTL, 32'h0);
    look(M3, REJ, "R5 hash disabled ignores table");
  endtask

  task automatic t_prio();
    wr(A_CTL, 32'h2);
    set_entry(2, M3);
    look(M3, EXA, "R11 exact wins over group");
    look(M1, GRP, "R11 other group still hash hit");
  endtask

  task automatic t_promisc();
    wr(A_CTL, 32'h1);
    look(UNK, PRO, "R6 copy-all accepts unknown");
    look(STN, EXA, "R6 exact reported under copy-all");
    look(M1, REJ ^ PRO, "R6 group with hash off is promiscuous");
  endtask

  task automatic t_bcast();
    set_entry(4, BCAST);
    wr(A_CTL, 32'h6);
    look(BCAST, REJ, "R7 broadcast blocked despite entry and hash");
    wr(A_CTL, 32'h7);
    look(BCAST, PRO, "R7 copy-all overrides block");
    wr(A_CTL, 32'h0);
    look(BCAST, EXA, "R7 broadcast held in entry reports exact");
  endtask

  task automatic t_latency();
    look(STN, EXA, "R8 decision one cycle after strobe");
    @(negedge clk);
    chk(!dec_valid && !dec_accept, "R8 no decision without strobe",
        {62'd0, dec_valid, dec_accept}, 64'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; da_valid = 1'b0;
    wr_addr = '0; wr_data = '0; da = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_arming();
    t_same_cycle();
    t_hash();
    t_hash_off();
    t_prio();
    t_promisc();
    t_bcast();
    t_latency();
    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule